// File: doc/BRIEF.md
# Masked Channel Change Event Generator

This block watches a bank of binary channel states that arrive as periodic parallel samples. Each accepted sample is compared bit for bit with the sample accepted before it. Every channel whose level differs, and whose bit in a writable enable mask is set, yields one event. An event carries the channel number and whether the channel went high or low.

The events from one sample leave one at a time on a valid/ready output, lowest channel number first. The sample input has its own valid/ready handshake. It refuses a new sample until every event from the current one has been taken, so no change is ever lost or merged. The stored copy of the last sample is always refreshed with the full new word, masked bits included. A channel that changes while it is masked therefore does not raise a late event when it is enabled again.

Top module: `chan_evt_gen`

## Requirements
- R1: After reset, `samp_ready` is 1, `evt_valid` is 0, every channel is enabled and the stored last sample is all zeros. A first sample therefore raises a rising event for each channel that reads 1.
- R2: The set of changed channels is the bitwise XOR of the stored and the new sample. A sample equal to the stored one produces no event, and `samp_ready` stays 1.
- R3: A changed channel produces an event only if its mask bit is 1. The mask value in force on the cycle a sample is accepted decides this. A mask write made while that sample's events drain does not change them.
- R4: `evt_rise` is 1 when the channel's new level is 1 (rising) and 0 when it is 0 (falling).
- R5: On acceptance the stored sample takes all bits of the new sample, masked channels included. Sending that value again after unmasking produces no event.
- R6: The events of one sample leave in strictly ascending channel order, one per cycle with `evt_valid` and `evt_ready` both high. `evt_chan` is the binary channel number, from 0 to NCH-1.
- R7: While `evt_valid` is 1 and `evt_ready` is 0, `evt_valid`, `evt_chan` and `evt_rise` hold steady.
- R8: `samp_ready` is 0 while any event of the current sample is still pending. A sample offered then is not taken and does not change the stored sample.
- R9: When `mask_we` is 1, the mask takes `mask_wdata` at that clock edge. Bit i enables channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| samp_valid | input | 1 | A new sample is offered |
| samp_data | input | NCH | Channel levels of the offered sample |
| samp_ready | output | 1 | Block can take a sample this cycle |
| mask_we | input | 1 | Load the enable mask |
| mask_wdata | input | NCH | New enable mask, one bit per channel |
| evt_valid | output | 1 | An event is presented |
| evt_chan | output | $clog2(NCH) | Channel number of the event |
| evt_rise | output | 1 | 1 for a rising change, 0 for a falling change |
| evt_ready | input | 1 | Consumer takes the event |

## Verification
Some rules are checked by assertions on every cycle. The event payload must hold while the consumer stalls. Events within one sample must come out in ascending channel order. After acceptance no pending event may belong to a channel that was masked at that moment. The stored sample must equal the word just taken. The bench scenarios cover what needs a reference model. They show that the full set and the directions of events match the XOR of consecutive samples under the mask. They show that changes on masked channels are absorbed rather than deferred. They also show that mid-drain mask writes and refused samples leave both the current events and the next sample's result unchanged.

// File: rtl/chev_pkg.sv
package chev_pkg;
  // direction encoding carried on evt_rise
  typedef enum logic {
    CHEV_FALL = 1'b0,
    CHEV_RISE = 1'b1
  } chev_dir_e;
endpackage

// File: rtl/chev_rst_sync.sv
module chev_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/chev_mask_reg.sv
module chev_mask_reg #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [NCH-1:0] wdata,
  output logic [NCH-1:0] mask_q
);
  logic [NCH-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (we) mask_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/chev_sample_reg.sv
module chev_sample_reg #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic [NCH-1:0] data,
  output logic [NCH-1:0] prev_q
);
  logic [NCH-1:0] prev_d;

  always_comb begin
    prev_d = prev_q;
    if (take) prev_d = data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  // R5: the whole word is stored, masked bits included
  a_r5_prev_update: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (prev_q == $past(data)));
endmodule

// File: rtl/chev_serializer.sv
module chev_serializer #(
  parameter int NCH  = 32,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NCH-1:0]  load_vec,
  input  logic            pop,
  output logic [NCH-1:0]  pend_q,
  output logic            pend_any,
  output logic [IDXW-1:0] idx
);
  logic [NCH-1:0] pend_d;
  logic [NCH-1:0] clr_vec;
  logic           found;

  // lowest pending channel wins
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (pend_q[i] && !found) begin
        idx   = IDXW'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    clr_vec      = '0;
    clr_vec[idx] = 1'b1;
  end

  always_comb begin
    pend_d = pend_q;
    if (load)     pend_d = load_vec;
    else if (pop) pend_d = pend_q & ~clr_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_any = |pend_q;

  // R6: each following event of the same sample has a higher channel number
  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_any && pop) |=> (!pend_any || (idx > $past(idx))));
endmodule

// File: rtl/chan_evt_gen.sv
module chan_evt_gen #(
  parameter int NCH  = 32,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            samp_valid,
  input  logic [NCH-1:0]  samp_data,
  output logic            samp_ready,
  input  logic            mask_we,
  input  logic [NCH-1:0]  mask_wdata,
  output logic            evt_valid,
  output logic [IDXW-1:0] evt_chan,
  output logic            evt_rise,
  input  logic            evt_ready
);
  import chev_pkg::*;

  logic            rst_i_n;
  logic [NCH-1:0]  mask_q;
  logic [NCH-1:0]  prev_q;
  logic [NCH-1:0]  pend_q;
  logic [NCH-1:0]  change_vec;
  logic            pend_any;
  logic [IDXW-1:0] head_idx;
  logic            samp_fire;
  logic            evt_fire;
  chev_dir_e       head_dir;

  chev_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  chev_mask_reg #(.NCH(NCH)) u_mask (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .we     (mask_we),
    .wdata  (mask_wdata),
    .mask_q (mask_q)
  );

  chev_sample_reg #(.NCH(NCH)) u_prev (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .take   (samp_fire),
    .data   (samp_data),
    .prev_q (prev_q)
  );

  chev_serializer #(.NCH(NCH), .IDXW(IDXW)) u_ser (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (samp_fire),
    .load_vec (change_vec),
    .pop      (evt_fire),
    .pend_q   (pend_q),
    .pend_any (pend_any),
    .idx      (head_idx)
  );

  assign samp_ready = rst_i_n && !pend_any;
  assign samp_fire  = samp_valid && samp_ready;
  assign change_vec = (prev_q ^ samp_data) & mask_q;
  assign evt_fire   = evt_valid && evt_ready;

  // prev_q already holds the new sample while its events drain
  assign head_dir   = prev_q[head_idx] ? CHEV_RISE : CHEV_FALL;
  assign evt_valid  = pend_any;
  assign evt_chan   = head_idx;
  assign evt_rise   = (head_dir == CHEV_RISE);

  // R7: stalled event keeps its payload
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_chan) && $stable(evt_rise)));

  // R3: nothing pending for a channel masked at acceptance
  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    samp_fire |=> ((pend_q & ~$past(mask_q)) == '0));

  // R8: no sample taken while events remain
  a_r8_busy_refuse: assert property (@(posedge clk) disable iff (!rst_i_n)
    (evt_valid && !evt_ready) |=> !samp_ready);
endmodule

// File: tb/chan_evt_gen_tb.sv
`timescale 1ns/1ps
module chan_evt_gen_tb;
  localparam int NCH  = 32;
  localparam int IDXW = $clog2(NCH);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            samp_valid;
  logic [NCH-1:0]  samp_data;
  logic            samp_ready;
  logic            mask_we;
  logic [NCH-1:0]  mask_wdata;
  logic            evt_valid;
  logic [IDXW-1:0] evt_chan;
  logic            evt_rise;
  logic            evt_ready;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [NCH-1:0] prev_m;
  logic [NCH-1:0] mask_m;
  logic [31:0]    rng = 32'h1234_5678;

  always #4 clk = ~clk;

  chan_evt_gen #(.NCH(NCH)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_valid (samp_valid),
    .samp_data  (samp_data),
    .samp_ready (samp_ready),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .evt_valid  (evt_valid),
    .evt_chan   (evt_chan),
    .evt_rise   (evt_rise),
    .evt_ready  (evt_ready)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13;
    x ^= x >> 17;
    x ^= x << 5;
    return x;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_mask(input logic [NCH-1:0] m);
    @(negedge clk);
    mask_we = 1'b1; mask_wdata = m;
    @(negedge clk);
    mask_we = 1'b0;
    mask_m  = m;
  endtask

  // offer one sample, drain and check its events
  task automatic send(input logic [NCH-1:0] data, input int stall,
                      input bit wr_mid, input logic [NCH-1:0] mid_mask);
    logic [NCH-1:0] exp;
    bit first = 1'b1;
    @(negedge clk);
    chk(samp_ready === 1'b1, "R8", "ready before sample", 64'(samp_ready), 64'd1);
    samp_valid = 1'b1; samp_data = data;
    @(negedge clk);
    samp_valid = 1'b0;
    exp    = (prev_m ^ data) & mask_m;
    prev_m = data;
    for (int i = 0; i < NCH; i++) begin
      if (exp[i]) begin
        if (first && wr_mid) begin
          // R3: mask write during drain, events unchanged
          mask_we = 1'b1; mask_wdata = mid_mask;
          @(negedge clk);
          mask_we = 1'b0; mask_m = mid_mask;
        end
        first = 1'b0;
        for (int s = 0; s < stall; s++) begin
          samp_valid = 1'b1; samp_data = ~data;
          #1;
          chk(samp_ready === 1'b0, "R8", "ready while busy", 64'(samp_ready), 64'd0);
          chk(evt_valid === 1'b1 && evt_chan === IDXW'(i) && evt_rise === data[i],
              "R7", "held payload", {evt_valid, evt_chan, evt_rise},
              {1'b1, IDXW'(i), data[i]});
          @(negedge clk);
          samp_valid = 1'b0;
        end
        chk(evt_valid === 1'b1 && evt_chan === IDXW'(i), "R6", "event channel",
            {evt_valid, evt_chan}, {1'b1, IDXW'(i)});
        chk(evt_rise === data[i], "R4", "event direction", 64'(evt_rise), 64'(data[i]));
        evt_ready = 1'b1;
        @(negedge clk);
        evt_ready = 1'b0;
      end
    end
    chk(evt_valid === 1'b0, "R2", "no extra event", 64'(evt_valid), 64'd0);
    chk(samp_ready === 1'b1, "R2", "ready after drain", 64'(samp_ready), 64'd1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; samp_valid = 1'b0; samp_data = '0;
    mask_we = 1'b0; mask_wdata = '0; evt_ready = 1'b0;
    prev_m = '0; mask_m = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(samp_ready === 1'b1, "R1", "samp_ready after reset", 64'(samp_ready), 64'd1);
    chk(evt_valid === 1'b0, "R1", "evt_valid after reset", 64'(evt_valid), 64'd0);
    // R1: all enabled, stored zeros -> 32 rising events
    send('1, 0, 1'b0, '0);
    // R2: same sample, no events
    send('1, 0, 1'b0, '0);
    // R4: all falling
    send('0, 1, 1'b0, '0);
    // walking one over every channel
    for (int i = 0; i < NCH; i++) send(NCH'(1) << i, i % 3, 1'b0, '0);
    send('0, 0, 1'b0, '0);
    // R9: low half enabled
    write_mask(32'h0000_FFFF);
    send('1, 0, 1'b0, '0);
    // R5: masked changes absorbed, no late events
    write_mask('1);
    send('1, 0, 1'b0, '0);
    send('0, 2, 1'b0, '0);
    // R3: mask rewritten during drain
    send(32'hA5A5_5A5A, 2, 1'b1, 32'h0F0F_0F0F);
    send(32'h5A5A_A5A5, 1, 1'b1, '1);
    // random sweep
    for (int k = 0; k < 60; k++) begin
      logic [NCH-1:0] d;
      rng = nxt(rng); d = rng;
      if (k % 4 == 0) begin
        rng = nxt(rng);
        write_mask(rng);
      end
      rng = nxt(rng);
      send(d, int'(rng[1:0]), rng[2], nxt(rng));
    end
    write_mask('1);
    send('0, 0, 1'b0, '0);
    finish_run();
  end
endmodule